// File: doc/BRIEF.md
# Delay line calibration sequencer

This block is a small state machine that tunes a tapped clock delay line so that a phase-shifted sampling clock can be taken from it. A start request switches the delay line on and opens its sampling window. The block then tries the unit-delay settings one at a time, beginning at zero. After each new setting it waits for a fixed settle time and then reads the length feedback that the line reports. Each such step is a trial.

Once a trial gives acceptable feedback, the block takes the highest set tap of the length pattern and derives the output phase selection from it. It then closes the sampling window, leaves the line running and pulses done. If no trial is accepted, or the accepted pattern gives no usable tap, the block switches everything off and pulses error. A disable request shuts the line down at any time.

Top module: `dly_cal_seq`

## Requirements
- R1: A start request while idle sets the line enable and the sample enable in the same cycle. In that cycle busy rises, the unit-delay output becomes 0 and the phase select becomes 12.
- R2: During the sweep the phase select stays at 12 and the sample enable stays high. Each trial lasts SETTLE_CYC cycles. When a trial is rejected, the unit-delay output rises by exactly one.
- R3: A trial is accepted only if all three of these hold: the length-valid input is 1, the 12-bit length pattern is non-zero, and pattern bits 11 and 10 are not both 1.
- R4: If the trial at unit value 127 (the 128th trial) is rejected, the block pulses error. It also clears the line enable, the sample enable, the unit-delay output and the phase select.
- R5: After acceptance, N is the index of the highest set pattern bit. The search covers bits 10 down to 0, so bit 11 is not part of it. If N is 0, or bits 10..0 are all 0, the block pulses error and clears all control outputs.
- R6: On success the phase select becomes N/2+1, rounded down. The sample enable is cleared, the line enable stays 1, the unit-delay output keeps the accepted value, and done pulses.
- R7: A disable request takes priority over everything else. On the next edge it clears the line enable, the sample enable, the unit-delay output, the phase select and busy, and it produces neither done nor error.
- R8: A start request while busy is ignored: the sweep continues without restarting.
- R9: After reset every output is 0.
- R10: Done and error are pulses one cycle wide and never occur together. Busy falls in the same cycle as the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Calibration request |
| disable_i | input | 1 | Shut-down request, overrides start |
| len_valid_i | input | 1 | Length feedback valid flag from the delay line |
| len_pat_i | input | 12 | Length pattern feedback from the delay line |
| line_en_o | output | 1 | Delay line enable |
| samp_en_o | output | 1 | Sampling window enable |
| unit_o | output | 7 | Unit-delay setting |
| phase_o | output | 4 | Output phase selection |
| busy_o | output | 1 | Calibration in progress |
| done_o | output | 1 | One-cycle success pulse |
| err_o | output | 1 | One-cycle failure pulse |

## Verification
The bench models the delay line. Below a chosen unit value the line returns a rejected pattern; from that value on it returns a good one. Three kinds of rejection are used, so each acceptance condition is tested on its own: valid low, both top bits set, and a zero pattern. The good patterns are chosen to test the tap search and its error outcomes. 0x0F0 and 0x3FF give different phases. 0x400 checks the top tap of the search range. 0x800 and 0x001 must both lead to an error, which shows that bit 11 is excluded and that N of 0 is refused. A sweep with no accepted trial shows that the block gives up after exactly 128 trials. The number of cycles from start to the pulse shows the trial length and the single-step advance. A second start during a sweep, and a disable in the middle of a sweep, test the ignore and override rules.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_SWEEP = 1'b1
  } dcs_state_e;
endpackage

// File: rtl/dcs_settle_timer.sv
module dcs_settle_timer #(
  parameter int SETTLE_CYC = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic last_o
);
  localparam int CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CW-1:0] LAST_V = CW'(SETTLE_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign last_o = run_i && (cnt_q == LAST_V);

  // Counter restarts at every trial boundary and idles at zero.
  always_ff @(posedge clk) begin
    if (rst || !run_i || last_o) cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dcs_pat_eval.sv
module dcs_pat_eval #(
  parameter int PAT_W = 12,
  parameter int SEL_W = 4
) (
  input  logic             valid_i,
  input  logic [PAT_W-1:0] pat_i,
  output logic             accept_o,
  output logic             tap_ok_o,
  output logic [SEL_W-1:0] phase_o
);
  localparam int IW = $clog2(PAT_W);

  logic [IW-1:0] top_idx;
  logic          any_low;

  // Trial acceptance: valid, non-empty, not saturated at the two top taps.
  assign accept_o = valid_i && (pat_i != '0) && !(pat_i[PAT_W-1] && pat_i[PAT_W-2]);

  // Highest set tap in the search range (topmost bit excluded).
  always_comb begin
    top_idx = '0;
    any_low = 1'b0;
    for (int i = 0; i <= PAT_W - 2; i++) begin
      if (pat_i[i]) begin
        top_idx = IW'(i);
        any_low = 1'b1;
      end
    end
  end

  assign tap_ok_o = any_low && (top_idx != '0);
  assign phase_o  = SEL_W'(top_idx >> 1) + SEL_W'(1);
endmodule

// File: rtl/dly_cal_seq.sv
module dly_cal_seq #(
  parameter int UNIT_W     = 7,
  parameter int PAT_W      = 12,
  parameter int SEL_W      = 4,
  parameter int SWEEP_SEL  = 12,
  parameter int SETTLE_CYC = 100000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             disable_i,
  input  logic             len_valid_i,
  input  logic [PAT_W-1:0] len_pat_i,
  output logic             line_en_o,
  output logic             samp_en_o,
  output logic [UNIT_W-1:0] unit_o,
  output logic [SEL_W-1:0] phase_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);
  import dcs_pkg::*;

  localparam logic [UNIT_W-1:0] UNIT_LAST = {UNIT_W{1'b1}};
  localparam logic [SEL_W-1:0]  SEL_SWEEP = SEL_W'(SWEEP_SEL);

  dcs_state_e       state_q;
  logic             judge;
  logic             accept;
  logic             tap_ok;
  logic [SEL_W-1:0] phase_calc;

  dcs_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .run_i  (state_q == ST_SWEEP),
    .last_o (judge)
  );

  dcs_pat_eval #(.PAT_W(PAT_W), .SEL_W(SEL_W)) u_eval (
    .valid_i  (len_valid_i),
    .pat_i    (len_pat_i),
    .accept_o (accept),
    .tap_ok_o (tap_ok),
    .phase_o  (phase_calc)
  );

  assign busy_o = (state_q == ST_SWEEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      line_en_o <= 1'b0;
      samp_en_o <= 1'b0;
      unit_o    <= '0;
      phase_o   <= '0;
      done_o    <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      if (disable_i) begin
        state_q   <= ST_IDLE;
        line_en_o <= 1'b0;
        samp_en_o <= 1'b0;
        unit_o    <= '0;
        phase_o   <= '0;
      end else begin
        unique case (state_q)
          ST_IDLE: begin
            if (start_i) begin
              state_q   <= ST_SWEEP;
              line_en_o <= 1'b1;
              samp_en_o <= 1'b1;
              unit_o    <= '0;
              phase_o   <= SEL_SWEEP;
            end
          end
          ST_SWEEP: begin
            if (judge) begin
              if (accept && tap_ok) begin
                state_q   <= ST_IDLE;
                samp_en_o <= 1'b0;
                phase_o   <= phase_calc;
                done_o    <= 1'b1;
              end else if (accept || (unit_o == UNIT_LAST)) begin
                state_q   <= ST_IDLE;
                line_en_o <= 1'b0;
                samp_en_o <= 1'b0;
                unit_o    <= '0;
                phase_o   <= '0;
                err_o     <= 1'b1;
              end else begin
                unit_o <= unit_o + 1'b1;
              end
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/dly_cal_seq_chk.sv
module dly_cal_seq_chk #(
  parameter int UNIT_W    = 7,
  parameter int SEL_W     = 4,
  parameter int SWEEP_SEL = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              disable_i,
  input logic              line_en_o,
  input logic              samp_en_o,
  input logic [UNIT_W-1:0] unit_o,
  input logic [SEL_W-1:0]  phase_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o
);
  p_start_en_r1: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && start_i && !disable_i) |=>
      (line_en_o && samp_en_o && busy_o && unit_o == '0 && phase_o == SEL_W'(SWEEP_SEL)));

  p_sweep_hold_r2: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (line_en_o && samp_en_o && phase_o == SEL_W'(SWEEP_SEL)));

  p_unit_step_r2: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o) && unit_o != $past(unit_o)) |-> (unit_o == $past(unit_o) + 1'b1));

  p_err_clear_r4: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (!line_en_o && !samp_en_o && unit_o == '0 && phase_o == '0 && !busy_o));

  p_done_out_r6: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (line_en_o && !samp_en_o && !busy_o && phase_o != '0 && phase_o <= SEL_W'(6)));

  p_disable_r7: assert property (@(posedge clk) disable iff (rst)
    disable_i |=> (!line_en_o && !samp_en_o && !busy_o && !done_o && !err_o
                   && unit_o == '0 && phase_o == '0));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_err_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    err_o |=> !err_o);

  p_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(done_o && err_o));
endmodule

bind dly_cal_seq dly_cal_seq_chk #(
  .UNIT_W(UNIT_W), .SEL_W(SEL_W), .SWEEP_SEL(SWEEP_SEL)
) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .disable_i(disable_i),
  .line_en_o(line_en_o), .samp_en_o(samp_en_o), .unit_o(unit_o),
  .phase_o(phase_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/dly_cal_seq_tb.sv
`timescale 1ns/1ps
module dly_cal_seq_tb;
  localparam int SETTLE = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        disable_i = 1'b0;
  logic        len_valid_i;
  logic [11:0] len_pat_i;
  logic        line_en_o, samp_en_o, busy_o, done_o, err_o;
  logic [6:0]  unit_o;
  logic [3:0]  phase_o;

  // Delay-line model: good feedback from unit value 'target' upward.
  int          target;
  logic [11:0] good_pat, bad_pat;
  logic        bad_valid;
  assign len_valid_i = (int'(unit_o) >= target) ? 1'b1 : bad_valid;
  assign len_pat_i   = (int'(unit_o) >= target) ? good_pat : bad_pat;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  dly_cal_seq #(.SETTLE_CYC(SETTLE)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .disable_i(disable_i),
    .len_valid_i(len_valid_i), .len_pat_i(len_pat_i),
    .line_en_o(line_en_o), .samp_en_o(samp_en_o), .unit_o(unit_o),
    .phase_o(phase_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit ref_accept(input logic v, input logic [11:0] p);
    return v && (p != 0) && !(p[11] && p[10]);
  endfunction

  function automatic int ref_phase(input logic [11:0] p);
    for (int i = 10; i >= 1; i--) if (p[i]) return i / 2 + 1;
    return 0;
  endfunction

  // Run one calibration; 'target' = first good unit value (>=128: never).
  task automatic run_cal(input int tgt, input logic [11:0] gp, input logic bv,
                         input logic [11:0] bp, input bit restart, input string tag);
    int cyc;
    bit ok_exp;
    int exp_ph, exp_unit, exp_cyc;
    target = tgt; good_pat = gp; bad_valid = bv; bad_pat = bp;
    ok_exp  = (tgt < 128) && (ref_phase(gp) != 0) && ref_accept(1'b1, gp);
    exp_ph  = ok_exp ? ref_phase(gp) : 0;
    exp_unit= ok_exp ? tgt : 0;
    exp_cyc = ((tgt < 128) ? tgt + 1 : 128) * SETTLE;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    // R1: both enables together, unit 0, phase 12
    chk(line_en_o && samp_en_o && busy_o, {tag, " R1 enables"}, {line_en_o, samp_en_o, busy_o}, 7);
    chk(unit_o == 0 && phase_o == 12, {tag, " R1 unit/phase"}, phase_o, 12);
    cyc = 0;
    while (!done_o && !err_o && cyc < 5000) begin
      if (restart && cyc == 10) start_i = 1'b1;
      if (restart && cyc == 11) start_i = 1'b0;
      if (busy_o && (phase_o != 12 || !samp_en_o)) begin
        chk(1'b0, {tag, " R2 sweep hold"}, phase_o, 12);
      end
      @(negedge clk); cyc++;
    end
    chk(cyc == exp_cyc, {tag, " R2/R3/R8 trial cycles"}, cyc, exp_cyc);
    chk(done_o == ok_exp && err_o == !ok_exp, {tag, " R5/R6 outcome"}, done_o, ok_exp);
    chk(phase_o == exp_ph, {tag, " R6 phase"}, phase_o, exp_ph);
    chk(unit_o == exp_unit, {tag, " R6 unit"}, unit_o, exp_unit);
    chk(line_en_o == ok_exp && !samp_en_o && !busy_o, {tag, " R4/R6 enables"},
        {line_en_o, samp_en_o, busy_o}, ok_exp ? 4 : 0);
    @(negedge clk);
    chk(!done_o && !err_o, {tag, " R10 pulse width"}, {done_o, err_o}, 0);
  endtask

  task automatic t_reset();
    chk(!line_en_o && !samp_en_o && unit_o == 0 && phase_o == 0 && !busy_o && !done_o && !err_o,
        "R9 reset state", {line_en_o, samp_en_o, busy_o, done_o, err_o}, 0);
  endtask

  task automatic t_disable();
    target = 200; good_pat = 12'h0F0; bad_valid = 1'b0; bad_pat = 12'h000;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (30) @(negedge clk);
    chk(unit_o == 3, "R2 unit after 30 cycles", unit_o, 3);
    disable_i = 1'b1;
    @(negedge clk); disable_i = 1'b0;
    chk(!line_en_o && !samp_en_o && !busy_o && unit_o == 0 && phase_o == 0 && !done_o && !err_o,
        "R7 disable clears", {line_en_o, samp_en_o, busy_o, done_o, err_o}, 0);
    for (int k = 0; k < 3 * SETTLE; k++) begin
      @(negedge clk);
      if (done_o || err_o || busy_o) chk(1'b0, "R7 stays idle", {done_o, err_o, busy_o}, 0);
    end
    chk(!line_en_o, "R7 line stays off", line_en_o, 0);
  endtask

  initial begin : wd
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    target = 0; good_pat = 0; bad_pat = 0; bad_valid = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    run_cal(0,   12'h0F0, 1'b0, 12'h000, 1'b0, "first trial");   // R3 N=7 -> 4
    run_cal(5,   12'h3FF, 1'b1, 12'hC00, 1'b0, "top bits set");   // R3 reject 0xC00
    run_cal(9,   12'h400, 1'b0, 12'h0F0, 1'b0, "valid low");      // R3 reject valid=0, N=10 -> 6
    run_cal(4,   12'h006, 1'b1, 12'h000, 1'b0, "zero pattern");   // R3 reject zero, N=2 -> 2
    run_cal(3,   12'h0F0, 1'b0, 12'h000, 1'b1, "restart busy");   // R8
    run_cal(200, 12'h0F0, 1'b1, 12'hFFF, 1'b0, "exhaust");        // R4
    run_cal(2,   12'h800, 1'b0, 12'h000, 1'b0, "bit11 only");     // R5 error
    run_cal(1,   12'h001, 1'b0, 12'h000, 1'b0, "N zero");         // R5 error
    t_disable();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule